// File: doc/BRIEF.md
# Interrupt Status Collector with Ranked Error Code

This block gathers single-cycle event strobes from a card host controller into a sticky raw status register, and gathers strobes from its DMA engine into a separate sticky DMA status register. Software clears a bit in either register by writing a 1 to its position. A per-bit enable mask selects which raw bits may raise the single interrupt line, and a global enable gates that line without disturbing any stored bit.

From the enabled raw bits and the DMA status, a fixed priority encoder produces one error code. Software can then read a single field to learn the most important failure, with no need to decode two registers. Completion bits do not take part in the ranking. A DMA failure is reported only when no enabled card error is pending.

All register state is also available at the ports, so an external read mux can present it. A small write port reaches the raw status, the mask, the DMA status and the global enable.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, raw status, mask, DMA status, global enable, irq and err_code are all zero.
- R2: An event strobe on ev_raw[i] for one cycle sets raw_q[i] at that clock edge, and the bit stays set until it is cleared.
- R3: A write to address 0 clears every raw_q bit whose wr_data bit is 1 and leaves bits written 0 unchanged. Writing all ones clears every raw bit.
- R4: If an event strobe and a clearing write reach the same bit in the same cycle, the bit ends up set. This applies to both status registers.
- R5: masked_q equals raw_q AND mask_q, where the mask is written at address 1. irq is 1 exactly when masked_q is nonzero and gie_q is 1.
- R6: gie_q is wr_data[0] written at address 3. When gie_q is 0, irq is 0 and no status bit changes.
- R7: Raw bit positions are: 0 command done, 1 response error, 2 response CRC, 3 transfer done, 4 data CRC, 5 response timeout, 6 data timeout, 7 data starvation, 8 FIFO under/overflow, 9 command busy/illegal write, 10 data start-bit error, 11 data end-bit error, 12 auto-stop done. err_code ranks the enabled error bits, highest first, with these codes: starvation=1, FIFO=2, busy/illegal write=3, response timeout=4, response CRC=5, response error=6, data timeout=7, data CRC=8, start-bit=9, end-bit=10.
- R8: err_code is 0 when no enabled error bit and no DMA error bit is set. Bits 0, 3, 12 and 13-15 of the raw status never change err_code, and a raw error bit cleared in mask_q does not count.
- R9: The DMA status register is 10 bits wide. ev_dma sets its bits, and a write to address 2 clears the positions written 1. Writing 0x3FF clears every bit.
- R10: DMA bit 2 (fatal bus error) or DMA bit 4 (descriptor unavailable) gives err_code 11, but only when no enabled card error is set. The other DMA bits never change err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_raw | input | 16 | Card event strobes, one per raw status bit |
| ev_dma | input | 10 | DMA event strobes, one per DMA status bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 raw status, 1 mask, 2 DMA status, 3 global enable |
| wr_data | input | 16 | Write data |
| raw_q | output | 16 | Raw status register |
| mask_q | output | 16 | Per-bit enable mask |
| dma_q | output | 10 | DMA status register |
| gie_q | output | 1 | Global interrupt enable |
| masked_q | output | 16 | Raw status ANDed with mask |
| irq | output | 1 | Interrupt line |
| err_code | output | 4 | Highest-ranked pending error, 0 for none |

## Verification
Every register takes a strobe or a write at one rising edge, and the new value appears on its output right after that edge. masked_q, irq and err_code are combinational from those registers, so they are due in the same cycle as the register they depend on. The bench drives its inputs a little after a rising edge and holds them for exactly one edge. It then removes them and samples a little after that edge, so each check sees the result of exactly one edge. The priority order is covered by setting all error bits at once and clearing the winner one bit at a time, with the expected code read from a list held in the bench.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int STAT_W = 16,
  parameter int DMA_W  = 10,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_raw,
  input  logic [DMA_W-1:0]  ev_dma,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] raw_q,
  output logic [STAT_W-1:0] mask_q,
  output logic [DMA_W-1:0]  dma_q,
  output logic              gie_q,
  output logic [STAT_W-1:0] masked_q,
  output logic              irq,
  output logic [CODE_W-1:0] err_code
);
  localparam logic [1:0] A_RAW = 2'd0, A_MASK = 2'd1, A_DMA = 2'd2, A_CTL = 2'd3;

  localparam int B_RSP_ERR = 1,  B_RSP_CRC = 2,  B_DAT_CRC = 4,  B_RSP_TO = 5;
  localparam int B_DAT_TO  = 6,  B_STARVE  = 7,  B_FIFO    = 8,  B_BUSY   = 9;
  localparam int B_DSTART  = 10, B_DEND    = 11;
  localparam int D_FATAL   = 2,  D_NODESC  = 4;

  logic [STAT_W-1:0] raw_clr;
  logic [DMA_W-1:0]  dma_clr;

  assign raw_clr = (wr_en && wr_addr == A_RAW) ? wr_data : '0;
  assign dma_clr = (wr_en && wr_addr == A_DMA) ? wr_data[DMA_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      dma_q  <= '0;
      gie_q  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~raw_clr) | ev_raw;
      dma_q <= (dma_q & ~dma_clr) | ev_dma;
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
      if (wr_en && wr_addr == A_CTL)  gie_q  <= wr_data[0];
    end
  end

  assign masked_q = raw_q & mask_q;
  assign irq      = gie_q & (|masked_q);

  always_comb begin
    if      (masked_q[B_STARVE])                   err_code = CODE_W'(1);
    else if (masked_q[B_FIFO])                     err_code = CODE_W'(2);
    else if (masked_q[B_BUSY])                     err_code = CODE_W'(3);
    else if (masked_q[B_RSP_TO])                   err_code = CODE_W'(4);
    else if (masked_q[B_RSP_CRC])                  err_code = CODE_W'(5);
    else if (masked_q[B_RSP_ERR])                  err_code = CODE_W'(6);
    else if (masked_q[B_DAT_TO])                   err_code = CODE_W'(7);
    else if (masked_q[B_DAT_CRC])                  err_code = CODE_W'(8);
    else if (masked_q[B_DSTART])                   err_code = CODE_W'(9);
    else if (masked_q[B_DEND])                     err_code = CODE_W'(10);
    else if (dma_q[D_FATAL] || dma_q[D_NODESC])    err_code = CODE_W'(11);
    else                                           err_code = '0;
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int STAT_W = 16,
  parameter int DMA_W  = 10,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] ev_raw,
  input logic [DMA_W-1:0]  ev_dma,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [STAT_W-1:0] wr_data,
  input logic [STAT_W-1:0] raw_q,
  input logic [DMA_W-1:0]  dma_q,
  input logic              gie_q,
  input logic [STAT_W-1:0] masked_q,
  input logic              irq,
  input logic [CODE_W-1:0] err_code
);
  localparam logic [STAT_W-1:0] ERR_BITS = STAT_W'(16'h0FF6);
  localparam logic [DMA_W-1:0]  DMA_ERR  = DMA_W'(10'h014);

  AST_RAW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & $past(ev_raw)) == $past(ev_raw))); // R2

  AST_DMA_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((dma_q & $past(ev_dma)) == $past(ev_dma))); // R4

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & ~$past(raw_q) & ~$past(ev_raw)) == '0)); // R2

  AST_RAW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) == 2'd0)
      |-> ((raw_q & $past(wr_data) & ~$past(ev_raw)) == '0)); // R3

  AST_DMA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) == 2'd2)
      |-> ((dma_q & $past(wr_data[DMA_W-1:0]) & ~$past(ev_dma)) == '0)); // R9

  AST_GIE_GATES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq); // R6

  AST_LINE_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && masked_q != '0) |-> irq); // R5

  AST_NO_ERROR_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_q & ERR_BITS) == '0 && (dma_q & DMA_ERR) == '0) |-> (err_code == '0)); // R8

  AST_DMA_RANKS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_q & ERR_BITS) != '0) |-> (err_code != CODE_W'(11) && err_code != '0)); // R10
endmodule

bind irq_status_unit irq_status_unit_chk #(.STAT_W(STAT_W), .DMA_W(DMA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_raw(ev_raw), .ev_dma(ev_dma), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .raw_q(raw_q), .dma_q(dma_q),
  .gie_q(gie_q), .masked_q(masked_q), .irq(irq), .err_code(err_code)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_raw = '0;
  logic [9:0]  ev_dma = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] raw_q, mask_q, masked_q;
  logic [9:0]  dma_q;
  logic        gie_q, irq;
  logic [3:0]  err_code;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ev_raw(ev_raw), .ev_dma(ev_dma), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .raw_q(raw_q), .mask_q(mask_q),
    .dma_q(dma_q), .gie_q(gie_q), .masked_q(masked_q), .irq(irq), .err_code(err_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] er, input logic [9:0] ed,
                     input logic we, input logic [1:0] a, input logic [15:0] d);
    ev_raw = er; ev_dma = ed; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    ev_raw = '0; ev_dma = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc('0, '0, 1'b1, a, d);
  endtask

  task automatic clean();
    wr(2'd0, 16'hFFFF); wr(2'd2, 16'h03FF); wr(2'd1, 16'h0000); wr(2'd3, 16'h0000);
  endtask

  task automatic t_reset();
    check("R1 raw", raw_q, 0);
    check("R1 mask", mask_q, 0);
    check("R1 dma", dma_q, 0);
    check("R1 gie", gie_q, 0);
    check("R1 irq", irq, 0);
    check("R1 code", err_code, 0);
  endtask

  task automatic t_set_clear();
    cyc(16'h0009, '0, 1'b0, 2'd0, '0);
    check("R2 set", raw_q, 16'h0009);
    cyc('0, '0, 1'b0, 2'd0, '0);
    check("R2 hold", raw_q, 16'h0009);
    cyc(16'hA000, '0, 1'b0, 2'd0, '0);
    wr(2'd0, 16'h0001);
    check("R3 clear one", raw_q, 16'hA008);
    wr(2'd0, 16'h0000);
    check("R3 write zero", raw_q, 16'hA008);
    wr(2'd0, 16'hFFFF);
    check("R3 clear all", raw_q, 16'h0000);
  endtask

  task automatic t_collision();
    cyc(16'h0010, 10'h001, 1'b0, 2'd0, '0);
    cyc(16'h0010, '0, 1'b1, 2'd0, 16'hFFFF);
    check("R4 raw set wins", raw_q, 16'h0010);
    cyc('0, 10'h001, 1'b1, 2'd2, 16'h03FF);
    check("R4 dma set wins", dma_q, 10'h001);
    clean();
  endtask

  task automatic t_mask_irq();
    cyc(16'h1009, '0, 1'b0, 2'd0, '0);
    check("R5 irq no mask", irq, 0);
    wr(2'd1, 16'h0008);
    check("R5 masked", masked_q, 16'h0008);
    check("R5 irq gie off", irq, 0);
    wr(2'd3, 16'h0001);
    check("R6 gie set", gie_q, 1);
    check("R5 irq on", irq, 1);
    wr(2'd1, 16'h0004);
    check("R5 irq mask miss", irq, 0);
    wr(2'd1, 16'h1000);
    check("R5 irq bit12", irq, 1);
    wr(2'd3, 16'h0000);
    check("R6 irq gated", irq, 0);
    check("R6 status kept", raw_q, 16'h1009);
    clean();
  endtask

  task automatic t_priority();
    int order[10] = '{7, 8, 9, 5, 2, 1, 6, 4, 10, 11};
    wr(2'd1, 16'hFFFF);
    cyc(16'hF009, '0, 1'b0, 2'd0, '0);
    check("R8 non-error bits", err_code, 0);
    cyc(16'h0FF6, 10'h014, 1'b0, 2'd0, '0);
    for (int k = 0; k < 10; k++) begin
      check($sformatf("R7 rank %0d", k + 1), err_code, k + 1);
      wr(2'd0, 16'(1 << order[k]));
    end
    check("R10 dma error", err_code, 11);
    wr(2'd2, 16'h0004);
    check("R10 desc unavailable", err_code, 11);
    wr(2'd2, 16'h0010);
    check("R8 none left", err_code, 0);
    cyc('0, 10'h3EB, 1'b0, 2'd0, '0);
    check("R10 other dma bits", err_code, 0);
    wr(2'd2, 16'h03FF);
    check("R9 clear all", dma_q, 0);
    cyc(16'h0800, 10'h004, 1'b0, 2'd0, '0);
    check("R10 card beats dma", err_code, 10);
    wr(2'd1, 16'h0000);
    check("R8 masked out", err_code, 11);
    clean();
  endtask

  task automatic t_dma_w1c();
    cyc('0, 10'h2A5, 1'b0, 2'd0, '0);
    check("R9 set", dma_q, 10'h2A5);
    wr(2'd2, 16'h0021);
    check("R9 partial clear", dma_q, 10'h284);
    check("R9 raw untouched", raw_q, 0);
    clean();
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_set_clear();
    t_collision();
    t_mask_irq();
    t_priority();
    t_dma_w1c();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule